// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Queue

This block accepts 32-bit words from a host, keeps up to 32 of them in a first-in first-out queue, and sends each one on an ARINC 429 line as return-to-zero bipolar bit cells. It does not drive the line electrically. It drives two digital levels, `line_hi_a` and `line_hi_b`, that an external line driver turns into the differential bus voltage.

Bit timing comes from a 1 MHz enable pulse, `tick_1us`. A rate select chooses between high speed (100 kbit/s) and low speed (12.5 kbit/s). The label byte goes out first. The host can reverse its bit significance just before transmission. Bit 32 carries either generated odd parity or the host's own data bit. Consecutive words are separated by a null gap. The queue reports empty and full.

Top module: `a429_word_sender`

## Requirements
- R1: Words leave in the order they were accepted, and the queue holds at most 32 words of 32 bits.
- R2: With `label_rev`=0, wire bit position n (1 to 32, position 1 first in time) carries `wr_data[n-1]`, except position 32 when parity is enabled.
- R3: With `label_rev`=1, wire positions 1 to 8 carry `wr_data[7]` down to `wr_data[0]`, so position k carries `wr_data[8-k]`. Positions 9 to 31 are unchanged.
- R4: With `par_odd`=1, position 32 is set so that the 32 transmitted bits hold an odd number of ones. With `par_odd`=0, position 32 carries `wr_data[31]`.
- R5: A one bit drives A=1, B=0 in its drive phase. A zero bit drives A=0, B=1. Every null phase and idle period drives A=0, B=0, and A and B are never both 1.
- R6: With `rate_slow`=0, each bit cell is 5 ticks of drive followed by 5 ticks of null. With `rate_slow`=1, it is 40 ticks of drive followed by 40 ticks of null.
- R7: After the null phase of bit 32, the line stays null for 4 bit times (40 or 320 ticks). If the queue then holds a word, that word starts automatically. Its drive phase appears in the clock after the gap ends.
- R8: `q_empty` is 1 exactly when the queue holds no word, and `q_full` is 1 exactly when it holds 32. Both update in the clock after the write or removal that changes the count.
- R9: A write while `q_full`=1 is dropped and leaves the queued words unchanged.
- R10: During and right after reset, A and B are 0, `q_empty`=1 and `q_full`=0.
- R11: `label_rev`, `par_odd` and `rate_slow` are sampled when a word is taken from the queue. Changing them mid-word has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-clock enable pulse at 1 MHz |
| rate_slow | input | 1 | 0: 100 kbit/s, 1: 12.5 kbit/s |
| label_rev | input | 1 | Reverse label bit order on transmit |
| par_odd | input | 1 | 1: odd parity in bit 32, 0: bit 32 is data |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 32 | Word to queue; bit n-1 is ARINC bit n |
| q_empty | output | 1 | Queue holds no word |
| q_full | output | 1 | Queue holds 32 words |
| line_hi_a | output | 1 | Drive A leg high |
| line_hi_b | output | 1 | Drive B leg high |

## Verification
The bench pushes a burst of 40 writes into a queue that is draining one word, so 7 writes land on a full queue. A design that accepted one of them would shift every later word, and the decoded word order would no longer match. Words are sent with and without label reversal and with and without parity. A wrongly mirrored label or an even parity bit shows up as a decoded-word mismatch. The bench also changes the rate and the options partway through a low-speed word, and it checks the line level every clock against its own model. This catches cells or gaps that are one tick short or long, and any word that picks up a new setting mid-flight.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LABEL_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_NULL  = 2'd2,
    ST_GAP   = 2'd3
  } tx_state_t;
endpackage

// File: rtl/a429_txq.sv
module a429_txq #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH-1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign level   = cnt_q;
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr_q] <= din;
    end
  end
endmodule

// File: rtl/a429_frame_build.sv
module a429_frame_build #(
  parameter int unsigned W   = 32,
  parameter int unsigned LBL = 8
) (
  input  logic [W-1:0] word,
  input  logic         rev_label,
  input  logic         odd_par,
  output logic [W-1:0] frame
);
  logic par_bit;

  assign par_bit = ~(^word[W-2:0]);

  for (genvar k = 0; k < LBL; k++) begin : g_label
    assign frame[k] = rev_label ? word[LBL-1-k] : word[k];
  end

  for (genvar k = LBL; k < W-1; k++) begin : g_data
    assign frame[k] = word[k];
  end

  assign frame[W-1] = odd_par ? par_bit : word[W-1];
endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq
  import a429_tx_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter int unsigned FAST_HALF = 5,
  parameter int unsigned SLOW_HALF = 40,
  parameter int unsigned GAP_BITS  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rate_slow,
  input  logic         avail,
  input  logic [W-1:0] frame_in,
  output logic         take,
  output tx_state_t    state,
  output logic         line_a,
  output logic         line_b
);
  localparam int unsigned MAXCNT = 2 * GAP_BITS * SLOW_HALF;
  localparam int unsigned TW     = $clog2(MAXCNT + 1);
  localparam int unsigned BW     = $clog2(W);
  localparam logic [TW-1:0] FAST_END = TW'(FAST_HALF - 1);
  localparam logic [TW-1:0] SLOW_END = TW'(SLOW_HALF - 1);
  localparam logic [TW-1:0] FGAP_END = TW'(2 * GAP_BITS * FAST_HALF - 1);
  localparam logic [TW-1:0] SGAP_END = TW'(2 * GAP_BITS * SLOW_HALF - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  tx_state_t     st_q, st_d;
  logic [W-1:0]  sreg_q, sreg_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          slow_q, slow_d;
  logic [TW-1:0] half_end, gap_end;
  logic          half_done, gap_done;

  assign half_end  = slow_q ? SLOW_END : FAST_END;
  assign gap_end   = slow_q ? SGAP_END : FGAP_END;
  assign half_done = tick && (tcnt_q == half_end);
  assign gap_done  = tick && (tcnt_q == gap_end);
  assign take      = (st_q == ST_IDLE) && avail;

  always_comb begin
    st_d   = st_q;
    sreg_d = sreg_q;
    bit_d  = bit_q;
    tcnt_d = tcnt_q;
    slow_d = slow_q;
    case (st_q)
      ST_IDLE: begin
        if (avail) begin
          st_d   = ST_DRIVE;
          sreg_d = frame_in;
          bit_d  = '0;
          tcnt_d = '0;
          slow_d = rate_slow;
        end
      end
      ST_DRIVE: begin
        if (half_done) begin
          st_d   = ST_NULL;
          tcnt_d = '0;
        end else if (tick) begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      ST_NULL: begin
        if (half_done) begin
          tcnt_d = '0;
          if (bit_q == LAST_BIT) begin
            st_d = ST_GAP;
          end else begin
            st_d   = ST_DRIVE;
            bit_d  = bit_q + 1'b1;
            sreg_d = {1'b0, sreg_q[W-1:1]};
          end
        end else if (tick) begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_done) begin
          st_d   = ST_IDLE;
          tcnt_d = '0;
        end else if (tick) begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sreg_q <= '0;
      bit_q  <= '0;
      tcnt_q <= '0;
      slow_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
      tcnt_q <= tcnt_d;
      slow_q <= slow_d;
    end
  end

  assign state  = st_q;
  assign line_a = (st_q == ST_DRIVE) && sreg_q[0];
  assign line_b = (st_q == ST_DRIVE) && !sreg_q[0];
endmodule

// File: rtl/a429_word_sender.sv
module a429_word_sender
  import a429_tx_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned FAST_HALF = 5,
  parameter int unsigned SLOW_HALF = 40,
  parameter int unsigned GAP_BITS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1us,
  input  logic        rate_slow,
  input  logic        label_rev,
  input  logic        par_odd,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        q_empty,
  output logic        q_full,
  output logic        line_hi_a,
  output logic        line_hi_b
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] head_word;
  logic [WORD_W-1:0] frame;
  logic [CW-1:0]     level;
  logic              take;
  tx_state_t         seq_state;

  a429_txq #(.DEPTH(DEPTH), .W(WORD_W)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_en),
    .din   (wr_data),
    .pop   (take),
    .dout  (head_word),
    .empty (q_empty),
    .full  (q_full),
    .level (level)
  );

  a429_frame_build #(.W(WORD_W), .LBL(LABEL_W)) u_frame (
    .word      (head_word),
    .rev_label (label_rev),
    .odd_par   (par_odd),
    .frame     (frame)
  );

  a429_tx_seq #(
    .W(WORD_W), .FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF), .GAP_BITS(GAP_BITS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1us),
    .rate_slow (rate_slow),
    .avail     (!q_empty),
    .frame_in  (frame),
    .take      (take),
    .state     (seq_state),
    .line_a    (line_hi_a),
    .line_b    (line_hi_b)
  );
endmodule

// File: rtl/a429_word_sender_chk.sv
module a429_word_sender_chk
  import a429_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick_1us,
  input logic                       wr_en,
  input logic                       q_empty,
  input logic                       q_full,
  input logic                       line_hi_a,
  input logic                       line_hi_b,
  input logic                       take,
  input tx_state_t                  seq_state,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  // R5: the two legs are never driven high together
  a_r5_legs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_hi_a && line_hi_b));

  // R7: the word gap is all null
  a_r7_gap_null: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_GAP) |-> (!line_hi_a && !line_hi_b));

  // R6: between ticks an active word holds its line level
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1us && seq_state != ST_IDLE) |=> $stable({line_hi_a, line_hi_b}));

  // R9: a write on a full queue with no removal leaves the count alone
  a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && wr_en && !take) |=> (q_full && $stable(level)));

  // R1: occupancy never exceeds the depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH+1))'(DEPTH));

  // R8: a word is only taken from a non-empty queue
  a_r8_take_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !q_empty);

  // R8: empty and full never both set
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full));
endmodule

bind a429_word_sender a429_word_sender_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_1us  (tick_1us),
  .wr_en     (wr_en),
  .q_empty   (q_empty),
  .q_full    (q_full),
  .line_hi_a (line_hi_a),
  .line_hi_b (line_hi_b),
  .take      (take),
  .seq_state (seq_state),
  .level     (level)
);

// File: tb/a429_word_sender_bench.sv
`timescale 1ns/1ps
module a429_word_sender_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_1us = 1'b0;
  logic        rate_slow = 1'b0;
  logic        label_rev = 1'b0;
  logic        par_odd = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        q_empty, q_full, line_hi_a, line_hi_b;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string cur_req = "R5";

  always #2 clk = ~clk;

  a429_word_sender u_a429_word_sender (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .rate_slow(rate_slow),
    .label_rev(label_rev), .par_odd(par_odd), .wr_en(wr_en), .wr_data(wr_data),
    .q_empty(q_empty), .q_full(q_full), .line_hi_a(line_hi_a), .line_hi_b(line_hi_b)
  );

  // tick every third clock, driven away from the edge
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick_1us <= (tdiv == 0);
  end

  // expected wire order: index 0 is position 1 on the wire
  function automatic logic [31:0] wire_vec(logic [31:0] w, logic rev, logic par);
    logic [31:0] v;
    for (int k = 0; k < 32; k++) v[k] = w[k];
    if (rev) for (int k = 0; k < 8; k++) v[k] = w[7-k];
    if (par) v[31] = ((^w[30:0]) == 1'b0);
    return v;
  endfunction

  // behavioural reference model
  logic [31:0] q[$];
  logic [31:0] expq[$];
  string       tagq[$];
  int m_st, m_bit, m_tk, m_half, m_phase;
  logic [31:0] m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_st = 0; m_bit = 0; m_tk = 0; m_half = 5; m_phase = 0; m_vec = '0;
    end else begin
      int sz;
      bit do_pop, acc;
      sz = q.size();
      do_pop = (m_st == 0) && (sz > 0);
      acc = wr_en && (sz < 32);
      if (m_st == 1 && tick_1us) begin
        if (m_tk == m_half - 1) begin
          m_tk = 0;
          if (m_phase == 0) m_phase = 1;
          else begin
            m_phase = 0;
            if (m_bit == 31) m_st = 2; else m_bit++;
          end
        end else m_tk++;
      end else if (m_st == 2 && tick_1us) begin
        if (m_tk == 8 * m_half - 1) begin m_st = 0; m_tk = 0; end
        else m_tk++;
      end
      if (do_pop) begin
        logic [31:0] w;
        w = q.pop_front();
        m_vec = wire_vec(w, label_rev, par_odd);
        expq.push_back(m_vec);
        tagq.push_back(label_rev ? "R3" : (par_odd ? "R4" : "R2"));
        m_half = rate_slow ? 40 : 5;
        m_bit = 0; m_tk = 0; m_phase = 0; m_st = 1;
      end
      if (acc) q.push_back(wr_data);
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of every output
  always @(negedge clk) begin
    if (rst_n) begin
      logic ea, eb, ee, ef;
      string tg;
      ea = (m_st == 1) && (m_phase == 0) && m_vec[m_bit];
      eb = (m_st == 1) && (m_phase == 0) && !m_vec[m_bit];
      ee = (q.size() == 0);
      ef = (q.size() == 32);
      tg = (m_st == 2) ? "R7" : cur_req;
      chk({line_hi_a, line_hi_b} == {ea, eb}, tg, "line A/B", {30'd0, line_hi_a, line_hi_b}, {30'd0, ea, eb});
      chk({q_empty, q_full} == {ee, ef}, "R8", "empty/full", {30'd0, q_empty, q_full}, {30'd0, ee, ef});
    end
  end

  // wire decoder: recovers words from A/B drive phases
  logic        prev_act = 1'b0;
  int          dcnt = 0;
  int          dec_words = 0;
  logic [31:0] dbits;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_act = 1'b0; dcnt = 0;
    end else begin
      if ((line_hi_a || line_hi_b) && !prev_act) begin
        dbits[dcnt] = line_hi_a;
        dcnt++;
        if (dcnt == 32) begin
          logic [31:0] e;
          string t;
          dcnt = 0;
          dec_words++;
          if (expq.size() == 0) chk(1'b0, "R1", "unexpected word", dbits, '0);
          else begin
            e = expq.pop_front();
            t = tagq.pop_front();
            chk(dbits == e, t, "decoded word", dbits, e);
            chk(dbits == e, "R1", "word order", dbits, e);
          end
        end
      end
      prev_act = line_hi_a || line_hi_b;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic put(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(m_st == 0 && q.size() == 0 && dcnt == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int base;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({line_hi_a, line_hi_b, q_empty, q_full} == 4'b0010, "R10", "reset outputs",
        {28'd0, line_hi_a, line_hi_b, q_empty, q_full}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk({line_hi_a, line_hi_b, q_empty, q_full} == 4'b0010, "R10", "after release",
        {28'd0, line_hi_a, line_hi_b, q_empty, q_full}, 32'h2);

    // R2 / R4: plain order, with and without parity
    cur_req = "R5";
    par_odd = 1'b1; put(32'h8000_00A5); drain();
    par_odd = 1'b0; put(32'hC3F0_1E5A); drain();
    par_odd = 1'b1; put(32'h0000_0000); drain();
    // R3: reversed label
    label_rev = 1'b1; par_odd = 1'b0; put(32'h1234_5681); drain();
    label_rev = 1'b1; par_odd = 1'b1; put(32'hFFFF_FFFF); drain();
    label_rev = 1'b0;

    // R9 / R8: burst onto a full queue
    base = dec_words;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'h5A00_0000 ^ (i * 32'h0101_0133);
      par_odd = i[0];
      label_rev = i[1];
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(q_full == 1'b1, "R8", "full after burst", {31'd0, q_full}, 32'd1);
    chk(q_empty == 1'b0, "R8", "not empty after burst", {31'd0, q_empty}, 32'd0);
    cur_req = "R7";
    drain();
    chk(dec_words - base == 33, "R9", "words sent from burst", dec_words - base, 33);
    chk(q_empty == 1'b1, "R8", "empty after drain", {31'd0, q_empty}, 32'd1);

    // R6 / R11: slow rate, settings changed mid-word
    cur_req = "R6";
    rate_slow = 1'b1; label_rev = 1'b0; par_odd = 1'b1;
    put(32'hA5A5_0F0F);
    put(32'h0F0F_A5A5);
    repeat (600) @(negedge clk);
    cur_req = "R11";
    rate_slow = 1'b0; label_rev = 1'b1; par_odd = 1'b0;
    drain();
    chk(line_hi_a == 1'b0 && line_hi_b == 1'b0, "R5", "idle null", {30'd0, line_hi_a, line_hi_b}, 32'd0);
    finish_run();
  end
endmodule